// File: doc/BRIEF.md
# Three-Group Interrupt Cause Aggregator

This block gathers per-bit interrupt events from three sources (receive, transmit and miscellaneous) into three 32-bit latched cause words. Each source group has its own mask, which is changed only through separate set and clear write ports, and a run-time choice of how its cause word is acknowledged. Software either writes ones to the bits it has handled, or simply reads the word, which empties it.

A three-bit summary word records which groups currently hold unmasked pending causes. It latches and is emptied by reading it. A separate summary mask gates the single interrupt line to the host. A host handler reads the summary, masks the summary and the group it services, acknowledges that group's causes and then unmasks again. A hit that lands during the handler stays latched because new events win over clears.

The register bus is a one-request-per-cycle interface. A write takes effect at the clock edge that samples it. A read returns its data one cycle later, with a valid strobe.

Top module: `irq_cause_agg`

## Requirements
- R1: After reset, every cause word and every summary bit is 0, every group mask reads 0xFFFFFFFF, every group is in write-ones-to-clear mode, the summary mask reads 0xFFFFFFFF and `irq_o` is low.
- R2: An event bit high in a cycle sets the matching cause bit at that clock edge, even when the same edge also clears that bit by a write or a read.
- R3: In write-ones-to-clear mode, a write to the cause word (offset 0) clears exactly the bits written as 1. A read of it leaves it unchanged.
- R4: A write to the mode register (offset 5) selects clear-on-read when the data is 0xFFFFFFFF and write-ones-to-clear for any other value. The register reads back 0xFFFFFFFF or 0. In clear-on-read mode, a read of the cause word returns its value and empties it, and writes to it have no effect.
- R5: A write to offset 1 sets the mask bits written as 1. A write to offset 2 clears the mask bits written as 1. Bits written as 0 are unchanged. Offset 3 reads the mask.
- R6: Offset 4 reads the cause word ANDed with the inverted mask, and reading it never clears anything.
- R7: Summary bit g (0 receive, 1 transmit, 2 miscellaneous) sets one edge after its group holds an unmasked cause and then stays set. A read of the summary word (word address 0x18) returns it and clears it, except for bits whose group is still pending at that edge. Bits 31:3 read 0.
- R8: The summary mask (word address 0x19) stores bits 2:0 from a write, and its bits 31:3 read as 1.
- R9: `irq_o` is high exactly when some summary bit is set and its summary-mask bit is 0.
- R10: The transmit group keeps only bit 0 (general done) and bits 1 to TX_QUEUES (per-queue done, 24 by default). Events on its higher bits are ignored and those bits read 0.
- R11: Word addresses are group base (receive 0x00, transmit 0x08, miscellaneous 0x10) plus offset. A read returns data on `bus_rdata_o` with `bus_rvalid_o` high one cycle after the request. Offsets 1, 2, 6 and 7 and summary addresses 0x1A to 0x1F read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req_i | input | 1 | Register access request for this cycle |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 5 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid |
| rx_evt_i | input | 32 | Receive-group event bits |
| tx_evt_i | input | 32 | Transmit-group event bits |
| misc_evt_i | input | 32 | Miscellaneous-group event bits |
| irq_o | output | 1 | Interrupt to the host |

## Verification
Directed sequences cover four distinct conditions. One raises an event in the very cycle it is acknowledged, by write and by read, which separates set-wins from clear-wins. One reads a cause word in each mode, which shows whether a read empties it. One floods the transmit group with all ones, which exposes the bits above the per-queue range. One reads the summary while its group is still pending, which separates a sticky latch from a plain clear. A seeded random phase then mixes sparse events on all three groups with reads and writes to every address, including all-ones and zero data to the mode and mask ports. A reference model predicts every read word and the interrupt line each cycle, so mask, mode and summary interactions that no directed case reaches are still compared.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned N_GRP  = 3;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned OFF_W  = 3;
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  // group pages; the page index equals the summary bit position
  localparam logic [PAGE_W-1:0] PAGE_RX   = 2'd0;
  localparam logic [PAGE_W-1:0] PAGE_TX   = 2'd1;
  localparam logic [PAGE_W-1:0] PAGE_MISC = 2'd2;
  localparam logic [PAGE_W-1:0] PAGE_SUM  = 2'd3;

  // offsets inside a group page
  localparam logic [OFF_W-1:0] OFF_CAUSE = 3'd0;
  localparam logic [OFF_W-1:0] OFF_MSET  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_MCLR  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_MVAL  = 3'd3;
  localparam logic [OFF_W-1:0] OFF_VIEW  = 3'd4;
  localparam logic [OFF_W-1:0] OFF_MODE  = 3'd5;

  // offsets inside the summary page
  localparam logic [OFF_W-1:0] OFF_SCAUSE = 3'd0;
  localparam logic [OFF_W-1:0] OFF_SMASK  = 3'd1;
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_cause_group.sv
`timescale 1ns/1ps
module irq_cause_group #(
  parameter int unsigned             W    = 32,
  parameter logic        [W-1:0]     IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         wr_cause_i,
  input  logic         rd_cause_i,
  input  logic         wr_mset_i,
  input  logic         wr_mclr_i,
  input  logic         wr_mode_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cause_o,
  output logic [W-1:0] mask_o,
  output logic         cor_o,
  output logic         pend_o
);
  logic [W-1:0] cause_q, cause_d;
  logic [W-1:0] mask_q,  mask_d;
  logic         cor_q,   cor_d;
  logic [W-1:0] clr_vec;
  logic [W-1:0] evt_kept;
  logic         cause_en, mask_en, mode_en;

  // next-state logic
  always_comb begin
    evt_kept = evt_i & IMPL;
    clr_vec  = '0;
    if (cor_q) begin
      if (rd_cause_i) clr_vec = '1;
    end else if (wr_cause_i) begin
      clr_vec = wdata_i;
    end
    // events are ORed in after the clear so a same-edge hit survives
    cause_d  = ((cause_q & ~clr_vec) | evt_kept) & IMPL;
    cause_en = (|clr_vec) | (|evt_kept);

    mask_d = mask_q;
    if (wr_mset_i) mask_d = mask_q | wdata_i;
    if (wr_mclr_i) mask_d = mask_q & ~wdata_i;
    mask_en = wr_mset_i | wr_mclr_i;

    cor_d   = &wdata_i;
    mode_en = wr_mode_i;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
      cor_q   <= 1'b0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      if (mask_en)  mask_q  <= mask_d;
      if (mode_en)  cor_q   <= cor_d;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign cor_o   = cor_q;
  assign pend_o  = |(cause_q & ~mask_q);

  // R2: an event bit is present after the edge that sampled it
  assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & IMPL)) |=> ((cause_q & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

  // R4: a clear-on-read read with no new event leaves the word empty
  assert_cor_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_q && rd_cause_i && !(|evt_i)) |=> (cause_q == '0));

  // R3: a read in write-ones-to-clear mode loses no bit
  assert_w1c_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cor_q && rd_cause_i && !wr_cause_i) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R5: bits written to the set port are masked afterwards
  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  // R10: bits outside the implemented set never appear
  assert_impl_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & ~IMPL) == '0));
endmodule

// File: rtl/irq_summary.sv
`timescale 1ns/1ps
module irq_summary #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend_i,
  input  logic         rd_sum_i,
  input  logic         wr_smask_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] sum_o,
  output logic [N-1:0] smask_o,
  output logic         irq_o
);
  logic [N-1:0] sum_q,   sum_d;
  logic [N-1:0] smask_q, smask_d;
  logic         sum_en;

  always_comb begin
    sum_d   = (rd_sum_i ? '0 : sum_q) | pend_i;
    sum_en  = rd_sum_i | (|pend_i);
    smask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      smask_q <= '1;
    end else begin
      if (sum_en)     sum_q   <= sum_d;
      if (wr_smask_i) smask_q <= smask_d;
    end
  end

  assign sum_o   = sum_q;
  assign smask_o = smask_q;
  assign irq_o   = |(sum_q & ~smask_q);

  // R7: a pending group shows in the summary after the edge
  assert_sum_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_i) |=> ((sum_q & $past(pend_i)) == $past(pend_i)));

  // R7: without a read, summary bits only accumulate
  assert_sum_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sum_i |=> ((sum_q & $past(sum_q)) == $past(sum_q)));

  // R9: a fully masked summary keeps the line low
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&smask_q) |-> !irq_o);
endmodule

// File: rtl/irq_cause_agg.sv
`timescale 1ns/1ps
module irq_cause_agg #(
  parameter int unsigned TX_QUEUES = 24
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_req_i,
  input  logic                               bus_we_i,
  input  logic [irq_agg_pkg::ADDR_W-1:0]     bus_addr_i,
  input  logic [irq_agg_pkg::DATA_W-1:0]     bus_wdata_i,
  output logic [irq_agg_pkg::DATA_W-1:0]     bus_rdata_o,
  output logic                               bus_rvalid_o,
  input  logic [irq_agg_pkg::DATA_W-1:0]     rx_evt_i,
  input  logic [irq_agg_pkg::DATA_W-1:0]     tx_evt_i,
  input  logic [irq_agg_pkg::DATA_W-1:0]     misc_evt_i,
  output logic                               irq_o
);
  import irq_agg_pkg::*;

  localparam logic [DATA_W-1:0] TX_IMPL  = (DATA_W'(1) << (TX_QUEUES + 1)) - DATA_W'(1);
  localparam logic [DATA_W-1:0] ALL_IMPL = '1;

  logic                    rst_sync_n;
  logic [PAGE_W-1:0]       page;
  logic [OFF_W-1:0]        off;
  logic                    rd_req, wr_req;
  logic [DATA_W-1:0]       evt   [N_GRP];
  logic [DATA_W-1:0]       cause [N_GRP];
  logic [DATA_W-1:0]       mask  [N_GRP];
  logic [N_GRP-1:0]        cor;
  logic [N_GRP-1:0]        pend;
  logic [N_GRP-1:0]        sum, smask;
  logic                    rd_sum, wr_smask;
  logic [DATA_W-1:0]       rd_mux;
  logic [DATA_W-1:0]       rdata_q;
  logic                    rvalid_q;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign page   = bus_addr_i[ADDR_W-1:OFF_W];
  assign off    = bus_addr_i[OFF_W-1:0];
  assign rd_req = bus_req_i & ~bus_we_i;
  assign wr_req = bus_req_i &  bus_we_i;

  assign evt[PAGE_RX]   = rx_evt_i;
  assign evt[PAGE_TX]   = tx_evt_i;
  assign evt[PAGE_MISC] = misc_evt_i;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic sel;
    assign sel = (page == PAGE_W'(g));

    irq_cause_group #(
      .W    (DATA_W),
      .IMPL ((PAGE_W'(g) == PAGE_TX) ? TX_IMPL : ALL_IMPL)
    ) u_group (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .evt_i      (evt[g]),
      .wr_cause_i (wr_req & sel & (off == OFF_CAUSE)),
      .rd_cause_i (rd_req & sel & (off == OFF_CAUSE)),
      .wr_mset_i  (wr_req & sel & (off == OFF_MSET)),
      .wr_mclr_i  (wr_req & sel & (off == OFF_MCLR)),
      .wr_mode_i  (wr_req & sel & (off == OFF_MODE)),
      .wdata_i    (bus_wdata_i),
      .cause_o    (cause[g]),
      .mask_o     (mask[g]),
      .cor_o      (cor[g]),
      .pend_o     (pend[g])
    );
  end

  assign rd_sum   = rd_req & (page == PAGE_SUM) & (off == OFF_SCAUSE);
  assign wr_smask = wr_req & (page == PAGE_SUM) & (off == OFF_SMASK);

  irq_summary #(.N(N_GRP)) u_summary (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pend_i     (pend),
    .rd_sum_i   (rd_sum),
    .wr_smask_i (wr_smask),
    .wdata_i    (bus_wdata_i[N_GRP-1:0]),
    .sum_o      (sum),
    .smask_o    (smask),
    .irq_o      (irq_o)
  );

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    if (page == PAGE_SUM) begin
      if (off == OFF_SCAUSE) rd_mux = {{(DATA_W-N_GRP){1'b0}}, sum};
      if (off == OFF_SMASK)  rd_mux = {{(DATA_W-N_GRP){1'b1}}, smask};
    end else begin
      for (int g = 0; g < N_GRP; g++) begin
        if (page == PAGE_W'(g)) begin
          if (off == OFF_CAUSE) rd_mux = cause[g];
          if (off == OFF_MVAL)  rd_mux = mask[g];
          if (off == OFF_VIEW)  rd_mux = cause[g] & ~mask[g];
          if (off == OFF_MODE)  rd_mux = {DATA_W{cor[g]}};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (rd_req) rdata_q <= rd_mux;
      rvalid_q <= rd_req;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  // R11: a read of the summary word returns what the summary held
  assert_sum_read_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_sum |=> (bus_rvalid_o && (bus_rdata_o[N_GRP-1:0] == $past(sum))
                && (bus_rdata_o[DATA_W-1:N_GRP] == '0)));
endmodule

// File: tb/test_irq_cause_agg.sv
`timescale 1ns/1ps
module test_irq_cause_agg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic [31:0] rx_evt, tx_evt, misc_evt;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference state
  logic [31:0] m_cause [3];
  logic [31:0] m_mask  [3];
  logic        m_cor   [3];
  logic [2:0]  m_sum, m_smask;

  always #2.5 clk = ~clk;

  irq_cause_agg i_irq_cause_agg (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_i    (bus_req),
    .bus_we_i     (bus_we),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .bus_rvalid_o (bus_rvalid),
    .rx_evt_i     (rx_evt),
    .tx_evt_i     (tx_evt),
    .misc_evt_i   (misc_evt),
    .irq_o        (irq)
  );

  function automatic logic [31:0] impl_of(input int g);
    return (g == 1) ? 32'h01FF_FFFF : 32'hFFFF_FFFF;  // R10
  endfunction

  function automatic logic [31:0] model_read(input logic [4:0] a);
    int g = int'(a[4:3]);
    logic [2:0] o = a[2:0];
    if (g == 3) begin
      if (o == 3'd0) return {29'd0, m_sum};
      if (o == 3'd1) return {29'h1FFF_FFFF, m_smask};
      return 32'd0;
    end
    case (o)
      3'd0: return m_cause[g];
      3'd3: return m_mask[g];
      3'd4: return m_cause[g] & ~m_mask[g];
      3'd5: return {32{m_cor[g]}};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // one bus cycle; inputs driven at negedge, results sampled at the next negedge
  task automatic step(input logic req, input logic we, input logic [4:0] a,
                      input logic [31:0] wd, input logic [31:0] erx,
                      input logic [31:0] etx, input logic [31:0] emisc,
                      input string tag);
    logic [31:0] exp_rd;
    logic        exp_rv;
    logic [2:0]  pend_old;
    logic [31:0] ev [3];
    bus_req = req; bus_we = we; bus_addr = a; bus_wdata = wd;
    rx_evt = erx; tx_evt = etx; misc_evt = emisc;
    ev[0] = erx; ev[1] = etx; ev[2] = emisc;
    exp_rv = req && !we;
    exp_rd = model_read(a);
    @(posedge clk);
    for (int g = 0; g < 3; g++) pend_old[g] = |(m_cause[g] & ~m_mask[g]);
    if (exp_rv && a == 5'h18) m_sum = 3'b000;
    m_sum = m_sum | pend_old;
    if (req && we && a == 5'h19) m_smask = wd[2:0];
    for (int g = 0; g < 3; g++) begin
      logic [31:0] clr = 32'd0;
      logic hit = req && (int'(a[4:3]) == g);
      if (m_cor[g]) begin
        if (hit && !we && a[2:0] == 3'd0) clr = 32'hFFFF_FFFF;
      end else if (hit && we && a[2:0] == 3'd0) clr = wd;
      m_cause[g] = ((m_cause[g] & ~clr) | ev[g]) & impl_of(g);
      if (hit && we && a[2:0] == 3'd1) m_mask[g] = m_mask[g] | wd;
      if (hit && we && a[2:0] == 3'd2) m_mask[g] = m_mask[g] & ~wd;
      if (hit && we && a[2:0] == 3'd5) m_cor[g] = (wd == 32'hFFFF_FFFF);
    end
    @(negedge clk);
    bus_req = 1'b0; rx_evt = '0; tx_evt = '0; misc_evt = '0;
    check({tag, " R11 rvalid"}, {31'd0, bus_rvalid}, {31'd0, exp_rv});
    if (exp_rv) check({tag, " rdata"}, bus_rdata, exp_rd);
    check({tag, " R9 irq"}, {31'd0, irq}, {31'd0, |(m_sum & ~m_smask)});
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, 32'd0, 32'd0, 32'd0, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, a, d, 32'd0, 32'd0, 32'd0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 5'd0, 32'd0, 32'd0, 32'd0, 32'd0, tag);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int g = 0; g < 3; g++) begin
      m_cause[g] = '0; m_mask[g] = '1; m_cor[g] = 1'b0;
    end
    m_sum = '0; m_smask = '1;
    rst_n = 1'b0; bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rx_evt = 0; tx_evt = 0; misc_evt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd(5'h00, "R1 rx cause");
    rd(5'h0B, "R1 tx mask");
    rd(5'h15, "R1 misc mode");
    rd(5'h19, "R1 summary mask");
    rd(5'h18, "R1 summary");

    // R2: event and write-clear in the same cycle
    step(1'b1, 1'b1, 5'h00, 32'h8, 32'h8, 32'd0, 32'd0, "R2 set vs w1c");
    rd(5'h00, "R2 bit survives");
    // R3: read does not clear, write of ones does
    rd(5'h00, "R3 read keeps");
    wr(5'h00, 32'h8, "R3 w1c");
    rd(5'h00, "R3 cleared");

    // R5: mask ports
    wr(5'h02, 32'h0000_00F0, "R5 mask clear");
    rd(5'h03, "R5 mask readback");
    wr(5'h01, 32'h0000_0030, "R5 mask set");
    rd(5'h03, "R5 mask readback 2");

    // R6 / R7 / R9: unmasked receive event raises summary and irq
    wr(5'h19, 32'hFFFF_FFF8, "R8 summary unmask");
    rd(5'h19, "R8 summary mask readback");
    step(1'b0, 1'b0, 5'd0, 32'd0, 32'h0000_00C0, 32'd0, 32'd0, "R7 rx event");
    rd(5'h04, "R6 view");
    rd(5'h00, "R6 view did not clear");
    rd(5'h18, "R7 summary while pending");
    rd(5'h18, "R7 summary stays while pending");
    wr(5'h00, 32'h0000_00C0, "R3 ack rx");
    idle("R7 settle");
    rd(5'h18, "R7 summary after ack");
    rd(5'h18, "R7 summary empty");

    // R4: clear-on-read on the misc group
    wr(5'h15, 32'hFFFF_FFFF, "R4 select cor");
    rd(5'h15, "R4 mode readback");
    step(1'b0, 1'b0, 5'd0, 32'd0, 32'd0, 32'd0, 32'h0000_0105, "R4 misc event");
    wr(5'h10, 32'hFFFF_FFFF, "R4 write ignored");
    rd(5'h10, "R4 read returns");
    rd(5'h10, "R4 read emptied");
    step(1'b1, 1'b0, 5'h10, 32'd0, 32'd0, 32'd0, 32'h2, "R2 set vs cor");
    rd(5'h10, "R2 cor survivor");
    wr(5'h15, 32'h0000_0001, "R4 select w1c");
    rd(5'h15, "R4 mode back to w1c");

    // R10: transmit group bit range
    step(1'b0, 1'b0, 5'd0, 32'd0, 32'd0, 32'hFFFF_FFFF, 32'd0, "R10 tx flood");
    rd(5'h08, "R10 tx cause");
    wr(5'h08, 32'hFFFF_FFFF, "R10 tx ack");

    // R11: write-only and unused locations
    rd(5'h01, "R11 mset reads 0");
    rd(5'h07, "R11 unused offset");
    rd(5'h1C, "R11 unused summary");

    // seeded random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic [31:0] e0, e1, e2;
      int sel = $urandom_range(0, 3);
      d = (sel == 0) ? 32'hFFFF_FFFF : (sel == 1) ? 32'd0 : $urandom;
      e0 = ($urandom_range(0, 3) == 0) ? ($urandom & $urandom & $urandom) : 32'd0;
      e1 = ($urandom_range(0, 3) == 0) ? ($urandom & $urandom & $urandom) : 32'd0;
      e2 = ($urandom_range(0, 3) == 0) ? ($urandom & $urandom & $urandom) : 32'd0;
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)),
           d, e0, e1, e2, "RAND");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule